// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces data-memory addresses from a small bank of pointer state: four index registers, four modify (step) registers and four length registers. An access strobe selects one index register and one modify register. The block drives the index value that was current before the access, then steps that index by the chosen modify value. The length register that belongs to the chosen index confines the step to a circular buffer. A length of zero leaves the index free-running over the whole 14-bit space.

A separate modify strobe steps an index in the same way but issues no address. This is useful for skipping ahead in a buffer between accesses. A bit-reverse mode input mirrors the issued address bit for bit, for the scrambled access order of radix-2 FFT stages. The stored index is never reversed. All twelve registers can be written and read back through a simple register port. The memories and any bus sharing lie outside the block.

Top module: `circ_addr_gen`

## Requirements
- R1: When `rst` is high at a clock edge, every index, modify and length register clears to 0, and `addr_out`, `addr_valid` and `reg_rdata` clear to 0.
- R2: `reg_addr[3:2]` selects the register class and `reg_addr[1:0]` selects the register number within it. Class 0 is index, 1 is modify and 2 is length. A write with `reg_we` high lands at the clock edge. `reg_rdata` is registered: one edge after `reg_addr` is presented, it shows that register as it stood before that edge. Class 3 ignores writes and reads back 0.
- R3: An edge with `acc_en` high loads `addr_out` with the selected index as it stood before the edge, and sets `addr_valid` high for exactly that one following cycle.
- R4: With a nonzero power-of-two length L on the selected index, the step gives new I = base + ((I − base + M) mod L), where base = I − (I mod L). M is a 14-bit two's complement value, so a step below base wraps to the top of the buffer.
- R5: With a length of 0, the step gives new I = (I + M) mod 2^14.
- R6: An edge with `mod_en` high and `acc_en` low steps the selected index as in R4/R5. It leaves `addr_out` unchanged and drives `addr_valid` low.
- R7: With `bitrev_en` high during an access, `addr_out[k]` equals bit 13−k of the pre-step index. The stored index is stepped in normal bit order.
- R8: A register write to the same index register that is being stepped in that cycle wins: the written value is stored and the step is lost.
- R9: When `acc_en` and `mod_en` are both high, the block behaves as a single access: one address is issued and the index is stepped once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register class (bits 3:2) and number (bits 1:0) |
| reg_wdata | input | 14 | Register write data |
| reg_rdata | output | 14 | Registered read data for `reg_addr` |
| acc_en | input | 1 | Access strobe: issue address, then post-step |
| mod_en | input | 1 | Step-only strobe |
| idx_sel | input | 2 | Index register (and its length) selected for access or step |
| mod_sel | input | 2 | Modify register selected for access or step |
| bitrev_en | input | 1 | Reverse the bits of the issued address |
| addr_out | output | 14 | Issued address |
| addr_valid | output | 1 | High for the cycle after an access |

## Verification
The buffer-containment property assumes that every nonzero length is a power of two and that the index is not rewritten in the cycle it is checked. The stimulus therefore loads only lengths of 0 or 8. Modify magnitudes stay below the buffer length, both positive and two's complement negative. The write-priority checks drive a write and a step to the same index register in the same cycle, on purpose. Every other stimulus keeps writes and steps on separate cycles, so each expected value depends on one operation only.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    RC_INDEX  = 2'd0,
    RC_MODIFY = 2'd1,
    RC_LENGTH = 2'd2,
    RC_NONE   = 2'd3
  } reg_class_e;
endpackage

// File: rtl/cag_regfile.sv
module cag_regfile
  import cag_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  localparam int SW  = $clog2(NPTR)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  reg_class_e               wr_class,
  input  logic [SW-1:0]            wr_num,
  input  logic [AW-1:0]            wr_data,
  input  reg_class_e               rd_class,
  input  logic [SW-1:0]            rd_num,
  output logic [AW-1:0]            rd_data,
  input  logic                     upd_en,
  input  logic [SW-1:0]            upd_num,
  input  logic [AW-1:0]            upd_data,
  output logic [NPTR-1:0][AW-1:0]  idx_q,
  output logic [NPTR-1:0][AW-1:0]  mod_q,
  output logic [NPTR-1:0][AW-1:0]  len_q
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic hit_i, hit_m, hit_l;
    assign hit_i = wr_en && (wr_class == RC_INDEX)  && (wr_num == SW'(g));
    assign hit_m = wr_en && (wr_class == RC_MODIFY) && (wr_num == SW'(g));
    assign hit_l = wr_en && (wr_class == RC_LENGTH) && (wr_num == SW'(g));

    // index: a register write outranks the post-step
    always_ff @(posedge clk) begin
      if (rst)                               idx_q[g] <= '0;
      else if (hit_i)                        idx_q[g] <= wr_data;
      else if (upd_en && upd_num == SW'(g))  idx_q[g] <= upd_data;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mod_q[g] <= '0;
        len_q[g] <= '0;
      end else begin
        if (hit_m) mod_q[g] <= wr_data;
        if (hit_l) len_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rd_class)
        RC_INDEX:  rd_data <= idx_q[rd_num];
        RC_MODIFY: rd_data <= mod_q[rd_num];
        RC_LENGTH: rd_data <= len_q[rd_num];
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cag_modulo.sv
module cag_modulo #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] mask;
  logic [AW-1:0] sum;

  // With L a power of two, base is a multiple of L, so the offset
  // (I - base + M) mod L equals the low bits of I + M.
  always_comb begin
    mask = len - AW'(1);
    sum  = idx + step;
    if (len == '0) nxt = sum;
    else           nxt = (idx & ~mask) | (sum & mask);
  end
endmodule

// File: rtl/cag_bitrev.sv
module cag_bitrev #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] din,
  output logic [AW-1:0] dout
);
  for (genvar k = 0; k < AW; k++) begin : g_bit
    assign dout[k] = din[AW-1-k];
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cag_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  localparam int SW  = $clog2(NPTR),
  localparam int RAW = SW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  input  logic           acc_en,
  input  logic           mod_en,
  input  logic [SW-1:0]  idx_sel,
  input  logic [SW-1:0]  mod_sel,
  input  logic           bitrev_en,
  output logic [AW-1:0]  addr_out,
  output logic           addr_valid
);
  reg_class_e              rclass;
  logic [NPTR-1:0][AW-1:0] idx_q, mod_q, len_q;
  logic [AW-1:0]           cur_idx, nxt_idx, rev_idx, cur_len;
  logic                    upd_en;

  assign rclass  = reg_class_e'(reg_addr[RAW-1:SW]);
  assign upd_en  = acc_en || mod_en;
  assign cur_idx = idx_q[idx_sel];
  assign cur_len = len_q[idx_sel];

  cag_regfile #(.AW(AW), .NPTR(NPTR)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_we),
    .wr_class (rclass),
    .wr_num   (reg_addr[SW-1:0]),
    .wr_data  (reg_wdata),
    .rd_class (rclass),
    .rd_num   (reg_addr[SW-1:0]),
    .rd_data  (reg_rdata),
    .upd_en   (upd_en),
    .upd_num  (idx_sel),
    .upd_data (nxt_idx),
    .idx_q    (idx_q),
    .mod_q    (mod_q),
    .len_q    (len_q)
  );

  cag_modulo #(.AW(AW)) u_mod (
    .idx  (cur_idx),
    .step (mod_q[mod_sel]),
    .len  (cur_len),
    .nxt  (nxt_idx)
  );

  cag_bitrev #(.AW(AW)) u_rev (
    .din  (cur_idx),
    .dout (rev_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= acc_en;
      if (acc_en) addr_out <= bitrev_en ? rev_idx : cur_idx;
    end
  end

  // ---------------- assertions ----------------
  logic idx_written;
  logic len_pow2;
  assign idx_written = reg_we && (rclass == RC_INDEX) && (reg_addr[SW-1:0] == idx_sel);
  assign len_pow2    = (cur_len != '0) && ((cur_len & (cur_len - AW'(1))) == '0);

  p_valid_after_acc_r3: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_valid);

  p_valid_low_r6: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> !addr_valid);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mod_en && !acc_en) |=> $stable(addr_out));

  // R4: after a plain access, the stepped index stays in the issued address's buffer
  p_in_buffer_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !bitrev_en && !idx_written && len_pow2) |=>
      ((idx_q[$past(idx_sel)] & ~($past(cur_len) - AW'(1))) ==
       (addr_out & ~($past(cur_len) - AW'(1)))));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (idx_written && upd_en) |=> (idx_q[$past(idx_sel)] == $past(reg_wdata)));
endmodule

// File: tb/circ_addr_gen_tb.sv
module circ_addr_gen_tb;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [13:0] reg_wdata = '0;
  logic [13:0] reg_rdata;
  logic        acc_en = 1'b0;
  logic        mod_en = 1'b0;
  logic [1:0]  idx_sel = '0;
  logic [1:0]  mod_sel = '0;
  logic        bitrev_en = 1'b0;
  logic [13:0] addr_out;
  logic        addr_valid;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  circ_addr_gen u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_en(acc_en),
    .mod_en(mod_en), .idx_sel(idx_sel), .mod_sel(mod_sel),
    .bitrev_en(bitrev_en), .addr_out(addr_out), .addr_valid(addr_valid)
  );

  // {op(0 write,1 access), reg_addr, data, isel, msel, brev, expected addr}
  localparam logic [38:0] VEC [16] = '{
    {2'd0, 4'h0, 14'h0105, 2'd0, 2'd0, 1'b0, 14'h0000},
    {2'd0, 4'h4, 14'h0003, 2'd0, 2'd0, 1'b0, 14'h0000},
    {2'd0, 4'h8, 14'h0008, 2'd0, 2'd0, 1'b0, 14'h0000},
    {2'd1, 4'h0, 14'h0000, 2'd0, 2'd0, 1'b0, 14'h0105},
    {2'd1, 4'h0, 14'h0000, 2'd0, 2'd0, 1'b0, 14'h0100},
    {2'd1, 4'h0, 14'h0000, 2'd0, 2'd0, 1'b0, 14'h0103},
    {2'd1, 4'h0, 14'h0000, 2'd0, 2'd0, 1'b0, 14'h0106},
    {2'd0, 4'h5, 14'h3FFE, 2'd0, 2'd0, 1'b0, 14'h0000},
    {2'd1, 4'h0, 14'h0000, 2'd0, 2'd1, 1'b0, 14'h0101},
    {2'd1, 4'h0, 14'h0000, 2'd0, 2'd1, 1'b0, 14'h0107},
    {2'd0, 4'h1, 14'h3FFF, 2'd0, 2'd0, 1'b0, 14'h0000},
    {2'd0, 4'h6, 14'h0002, 2'd0, 2'd0, 1'b0, 14'h0000},
    {2'd1, 4'h0, 14'h0000, 2'd1, 2'd2, 1'b0, 14'h3FFF},
    {2'd1, 4'h0, 14'h0000, 2'd1, 2'd2, 1'b0, 14'h0001},
    {2'd1, 4'h0, 14'h0000, 2'd1, 2'd2, 1'b1, 14'h3000},
    {2'd1, 4'h0, 14'h0000, 2'd1, 2'd2, 1'b0, 14'h0005}
  };

  task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    reg_we = 0; acc_en = 0; mod_en = 0; bitrev_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [13:0] v);
    idle();
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  initial begin
    logic [13:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 addr_out", addr_out, 14'h0);
    check("R1 addr_valid", 14'(addr_valid), 14'h0);
    rd(4'h0, v); check("R1 I0", v, 14'h0);
    rd(4'h9, v); check("R1 L1", v, 14'h0);

    // table: R3 issue order, R4 modulo wrap both ways, R5 linear, R7 bit reverse
    for (int i = 0; i < 16; i++) begin
      logic [38:0] e;
      e = VEC[i];
      idle();
      reg_we   = (e[38:37] == 2'd0);
      acc_en   = (e[38:37] == 2'd1);
      reg_addr = e[36:33];
      reg_wdata = e[32:19];
      idx_sel  = e[18:17];
      mod_sel  = e[16:15];
      bitrev_en = e[14];
      @(negedge clk);
      if (e[38:37] == 2'd1) begin
        check($sformatf("R3/R4/R5/R7 vec%0d addr", i), addr_out, e[13:0]);
        check($sformatf("R3 vec%0d valid", i), 14'(addr_valid), 14'h1);
      end
    end
    idle();
    @(negedge clk);
    check("R3 valid one cycle", 14'(addr_valid), 14'h0);

    // R2 readback and ignored class
    rd(4'h0, v); check("R2 I0 readback", v, 14'h0105);
    rd(4'h1, v); check("R7 I1 unreversed", v, 14'h0007);
    rd(4'h5, v); check("R2 M1 readback", v, 14'h3FFE);
    reg_we = 1; reg_addr = 4'hC; reg_wdata = 14'h1234;
    @(negedge clk);
    rd(4'hC, v); check("R2 class3 reads 0", v, 14'h0);
    rd(4'h0, v); check("R2 class3 write no effect", v, 14'h0105);

    // R6 standalone modify
    idle(); mod_en = 1; idx_sel = 0; mod_sel = 0;
    @(negedge clk);
    check("R6 addr held", addr_out, 14'h0005);
    check("R6 valid low", 14'(addr_valid), 14'h0);
    rd(4'h0, v); check("R6 I0 stepped", v, 14'h0100);

    // R8 write outranks step
    idle(); acc_en = 1; idx_sel = 0; mod_sel = 0;
    reg_we = 1; reg_addr = 4'h0; reg_wdata = 14'h0200;
    @(negedge clk);
    check("R8 issued old index", addr_out, 14'h0100);
    rd(4'h0, v); check("R8 write wins", v, 14'h0200);

    // R9 both strobes: single step
    idle(); acc_en = 1; mod_en = 1; idx_sel = 0; mod_sel = 0;
    @(negedge clk);
    check("R9 address", addr_out, 14'h0200);
    check("R9 valid", 14'(addr_valid), 14'h1);
    rd(4'h0, v); check("R9 single step", v, 14'h0203);

    // R1 reset mid-run
    idle(); rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 addr cleared", addr_out, 14'h0);
    rd(4'h0, v); check("R1 I0 cleared", v, 14'h0);
    rd(4'h5, v); check("R1 M1 cleared", v, 14'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule